// File: doc/BRIEF.md
# Temperature limit event controller

This block watches a stream of signed temperature samples and raises an event output when the temperature leaves a programmed window or reaches a critical level. A host writes the high, low and critical limits and a configuration word through a simple parallel write port. It reads back those registers, together with the latest temperature and three trip flags, through a combinational read port. Each sample arrives with a valid strobe. The block keeps the most recent sample and updates the event one clock after either the stored temperature or a limit changes.

The event output has three modes. In comparator mode it follows the alarm window, with selectable hysteresis. In interrupt mode it is a latch that sets whenever the window state changes and is cleared by software. In critical-only mode it follows the critical trip alone. At or above the critical limit the event stays asserted in every mode. The output polarity and enable are programmable, and the open-drain pad is represented by a drive-low signal and its complement, a release signal. Two sticky lock bits protect the limits and the output setup until reset. A shutdown bit freezes the temperature and the event.

Register addresses are: 0 configuration, 1 high limit, 2 low limit, 3 critical limit, 4 temperature. Addresses 5 to 7 read zero. Configuration bits are:

| Bit | Meaning |
|---|---|
| 0 | mode: 0 comparator, 1 interrupt |
| 1 | polarity: 0 active-low, 1 active-high |
| 2 | critical-only |
| 3 | output enable |
| 4 | event status, read-only |
| 5 | clear, write-one, always reads 0 |
| 6 | alarm lock |
| 7 | critical lock |
| 8 | shutdown |
| 10:9 | hysteresis code |

Temperatures are 13-bit two's complement in units of 1/16 degree.

Top module: `temp_event_ctrl`

## Requirements
- R1: After reset, the configuration register and all three limit registers read 0x0000. The event output is released (drive-low 0, release 1), which is the disabled active-low state.
- R2: The temperature register reads {crit, high, low, temp[12:0]}. Bit 15 is 1 when temp >= critical limit, bit 14 is 1 when temp > high limit, and bit 13 is 1 when temp < low limit. None of these three bits depends on hysteresis or on any configuration bit.
- R3: Limit registers keep only write bits 12..2; bits 15..13 and 1..0 always read 0. A limit is compared as a 13-bit value in the same 1/16 degree units as the temperature.
- R4: In comparator mode the high trip asserts when temp > high and releases only when temp <= high − H. H in sixteenths of a degree is 0, 24, 48 or 96 for hysteresis codes 00, 01, 10 and 11.
- R5: In comparator mode the low trip asserts when temp < low − H and releases when temp >= low. The event follows the OR of the high and low trips.
- R6: With critical-only set, the event is asserted exactly when temp >= critical limit, whatever the window state.
- R7: In interrupt mode, every change of the window state sets the event latch, and a write with bit 5 set clears it. Bit 5 always reads 0. In comparator mode, writing bit 5 has no effect on the event.
- R8: While temp >= critical limit the event is asserted in every mode, and a clear write does not de-assert it.
- R9: When asserted, the output drives low if the polarity bit is 0 and releases if it is 1. With enable 0 the output sits at its inactive level: released for polarity 0, driven low for polarity 1. Bit 4 reads 1 exactly when the enabled event is asserted, whatever the polarity. The release signal is always the complement of drive-low.
- R10: Lock bit 6 blocks writes to the high and low limits, and lock bit 7 blocks writes to the critical limit. While either lock is set, bits 0, 1 and 3 cannot change and bit 8 cannot be set. While bit 6 is set, bit 2 cannot be set. The locks clear only at reset.
- R11: While shutdown is set, samples are ignored, the temperature register holds its value and the event keeps its state. The one exception is a clear write in interrupt mode, which still de-asserts an event that is not held by the critical trip.
- R12: A limit write is evaluated against the stored temperature, so the event can change one clock after the write with no new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| smp_valid | input | 1 | temperature sample strobe |
| smp_temp | input | 13 | signed sample, 1/16 degree units |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | write register address |
| wr_data | input | 16 | write data |
| rd_addr | input | 3 | read register address |
| rd_data | output | 16 | read data (combinational) |
| evt_drive_low | output | 1 | pad pulls the event line low |
| evt_release | output | 1 | pad releases the event line |

## Verification
The embedded assertions watch four things on every cycle:
- the critical trip always holds the event;
- locked limits stay unchanged across write attempts, and the lock bits stay set;
- the stored temperature stays unchanged during shutdown;
- the output sits at the polarity-dependent inactive level while disabled.

Only the bench's scenarios can show the remaining behaviour: the exact hysteresis thresholds in both directions, the interrupt latch setting and clearing, and the critical-only filtering. The same holds for the immediate reaction to a limit write, the shutdown exception for clear, and the blocking of individual configuration bits by the locks.

// File: rtl/temp_event_ctrl.sv
module temp_event_ctrl #(
  parameter int HYST_STEP = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [12:0] smp_temp,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        evt_drive_low,
  output logic        evt_release
);
  localparam int TW = 13;
  localparam int XW = TW + 1;
  localparam logic [2:0] A_CFG = 3'd0, A_HIGH = 3'd1, A_LOW = 3'd2, A_CRIT = 3'd3, A_TEMP = 3'd4;
  localparam logic signed [XW-1:0] H1 = XW'(HYST_STEP);
  localparam logic signed [XW-1:0] H2 = XW'(2 * HYST_STEP);
  localparam logic signed [XW-1:0] H3 = XW'(4 * HYST_STEP);

  logic [TW-1:0] t_q, hi_lim, lo_lim, cr_lim;
  logic mode_q, pol_q, conly_q, en_q, alock_q, clock_q, shdn_q;
  logic [1:0] hyst_q;
  logic hi_q, lo_q, crit_q, irq_q, evt_q;

  logic signed [XW-1:0] t_x, hi_x, lo_x, cr_x, hyst_v, hi_rel, lo_set;
  logic crit_st, hi_st, lo_st;
  logic hi_n, lo_n, crit_n, irq_n, evt_n;
  logic cfg_wr, clr_hit, lk, asserted;

  assign t_x  = {t_q[TW-1], t_q};
  assign hi_x = {hi_lim[TW-1], hi_lim};
  assign lo_x = {lo_lim[TW-1], lo_lim};
  assign cr_x = {cr_lim[TW-1], cr_lim};

  always_comb begin
    case (hyst_q)
      2'd1:    hyst_v = H1;
      2'd2:    hyst_v = H2;
      2'd3:    hyst_v = H3;
      default: hyst_v = '0;
    endcase
  end

  assign hi_rel  = hi_x - hyst_v;
  assign lo_set  = lo_x - hyst_v;
  assign crit_st = (t_x >= cr_x);
  assign hi_st   = (t_x > hi_x);
  assign lo_st   = (t_x < lo_x);

  assign cfg_wr  = wr_en && (wr_addr == A_CFG);
  assign clr_hit = cfg_wr && wr_data[5];
  assign lk      = alock_q | clock_q;

  always_comb begin
    if (shdn_q) begin
      hi_n   = hi_q;
      lo_n   = lo_q;
      crit_n = crit_q;
    end else begin
      hi_n   = hi_st ? 1'b1 : ((t_x <= hi_rel) ? 1'b0 : hi_q);
      lo_n   = (t_x < lo_set) ? 1'b1 : ((t_x >= lo_x) ? 1'b0 : lo_q);
      crit_n = crit_st;
    end
  end

  always_comb begin
    if (!mode_q)
      irq_n = 1'b0;
    else if ((hi_n | lo_n) != (hi_q | lo_q))
      irq_n = 1'b1;
    else if (clr_hit)
      irq_n = 1'b0;
    else
      irq_n = irq_q;
  end

  always_comb begin
    if (shdn_q)
      evt_n = (clr_hit && mode_q && !conly_q && !crit_q) ? 1'b0 : evt_q;
    else if (conly_q)
      evt_n = crit_n;
    else
      evt_n = crit_n | (mode_q ? irq_n : (hi_n | lo_n));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q <= '0;
      hi_lim <= '0;
      lo_lim <= '0;
      cr_lim <= '0;
      mode_q <= 1'b0;
      pol_q <= 1'b0;
      conly_q <= 1'b0;
      en_q <= 1'b0;
      alock_q <= 1'b0;
      clock_q <= 1'b0;
      shdn_q <= 1'b0;
      hyst_q <= 2'd0;
      hi_q <= 1'b0;
      lo_q <= 1'b0;
      crit_q <= 1'b0;
      irq_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      if (smp_valid && !shdn_q) t_q <= smp_temp;
      if (wr_en && wr_addr == A_HIGH && !alock_q) hi_lim <= {wr_data[12:2], 2'b00};
      if (wr_en && wr_addr == A_LOW  && !alock_q) lo_lim <= {wr_data[12:2], 2'b00};
      if (wr_en && wr_addr == A_CRIT && !clock_q) cr_lim <= {wr_data[12:2], 2'b00};
      if (cfg_wr) begin
        if (!lk) begin
          mode_q <= wr_data[0];
          pol_q  <= wr_data[1];
          en_q   <= wr_data[3];
        end
        conly_q <= alock_q ? (conly_q & wr_data[2]) : wr_data[2];
        shdn_q  <= lk ? (shdn_q & wr_data[8]) : wr_data[8];
        hyst_q  <= wr_data[10:9];
        alock_q <= alock_q | wr_data[6];
        clock_q <= clock_q | wr_data[7];
      end
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      crit_q <= crit_n;
      irq_q  <= irq_n;
      evt_q  <= evt_n;
    end
  end

  assign asserted      = en_q & evt_q;
  assign evt_drive_low = pol_q ? ~asserted : asserted;
  assign evt_release   = ~evt_drive_low;

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = {5'b0, hyst_q, shdn_q, clock_q, alock_q, 1'b0, asserted, en_q, conly_q, pol_q, mode_q};
      A_HIGH:  rd_data = {3'b0, hi_lim};
      A_LOW:   rd_data = {3'b0, lo_lim};
      A_CRIT:  rd_data = {3'b0, cr_lim};
      A_TEMP:  rd_data = {crit_st, hi_st, lo_st, t_q};
      default: rd_data = 16'h0000;
    endcase
  end

  AST_CRIT_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n) crit_q |-> evt_q); // R8
  AST_ALARM_LIMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (alock_q && wr_en && (wr_addr == A_HIGH || wr_addr == A_LOW)) |=> ($stable(hi_lim) && $stable(lo_lim))); // R10
  AST_CRIT_LIMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (clock_q && wr_en && wr_addr == A_CRIT) |=> $stable(cr_lim)); // R10
  AST_LOCKS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alock_q || clock_q) |=> ($past(alock_q) <= alock_q && $past(clock_q) <= clock_q)); // R10
  AST_SHDN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) shdn_q |=> $stable(t_q)); // R11
  AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (evt_drive_low == pol_q && evt_release != evt_drive_low)); // R9
endmodule

// File: tb/test_temp_event_ctrl.sv
module test_temp_event_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [12:0] smp_temp = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        evt_drive_low, evt_release;

  temp_event_ctrl i_temp_event_ctrl (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_drive_low(evt_drive_low), .evt_release(evt_release));

  int errs = 0;
  int checks = 0;
  bit pol_b = 1'b0;
  bit done = 1'b0;

  // comparator walk, limits high 1280, low 80, hysteresis code 01 (24): {expected event, temp}
  localparam logic [13:0] VEC [13] = '{
    {1'b0, 13'd1000}, {1'b1, 13'd1281}, {1'b1, 13'd1280}, {1'b1, 13'd1257},
    {1'b0, 13'd1256}, {1'b0, 13'd1280}, {1'b0, 13'd90},   {1'b0, 13'd56},
    {1'b1, 13'd55},   {1'b1, 13'd79},   {1'b0, 13'd80},   {1'b1, 13'h1FF0},
    {1'b0, 13'd80}};

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    settle();
  endtask

  task automatic smp(input logic [12:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_temp = v;
    @(negedge clk);
    smp_valid = 1'b0;
    settle();
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic evt_chk(input string tag, input bit e);
    check(tag, {15'b0, evt_drive_low}, {15'b0, pol_b ? !e : e});
    check(tag, {15'b0, evt_release}, {15'b0, pol_b ? e : !e});
    rd_addr = 3'd0;
    #1;
    check(tag, {15'b0, rd_data[4]}, {15'b0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 cfg", 3'd0, 16'h0000);
    rd_chk("R1 high", 3'd1, 16'h0000);
    rd_chk("R1 low", 3'd2, 16'h0000);
    rd_chk("R1 crit", 3'd3, 16'h0000);
    evt_chk("R1 output", 1'b0);
    rd_chk("R2 zero temp vs zero crit", 3'd4, 16'h8000);

    // R3 limit field masking
    wr(3'd1, 16'hFFFF); rd_chk("R3 high mask", 3'd1, 16'h1FFC);
    wr(3'd2, 16'hE003); rd_chk("R3 low mask", 3'd2, 16'h0000);
    wr(3'd1, 16'h0500); wr(3'd2, 16'h0050); wr(3'd3, 16'h0640);

    // R2 trip status bits
    smp(13'd1700);  rd_chk("R2 above crit", 3'd4, 16'hC6A4);
    smp(13'd1600);  rd_chk("R2 equal crit", 3'd4, 16'hC640);
    smp(13'd1599);  rd_chk("R2 below crit", 3'd4, 16'h463F);
    smp(13'd1280);  rd_chk("R2 equal high", 3'd4, 16'h0500);
    smp(13'd50);    rd_chk("R2 below low", 3'd4, 16'h2032);
    smp(13'h1FF0);  rd_chk("R2 negative", 3'd4, 16'h3FF0);
    smp(13'd80);    rd_chk("R2 equal low", 3'd4, 16'h0050);

    // R4 / R5 comparator walk with 1.5 degree hysteresis
    wr(3'd0, 16'h0208);
    for (int i = 0; i < 13; i++) begin
      smp(VEC[i][12:0]);
      evt_chk(i < 6 ? "R4 high trip" : "R5 low trip", VEC[i][13]);
    end
    wr(3'd0, 16'h0608);
    smp(13'd1300); evt_chk("R4 hyst 6 set", 1'b1);
    smp(13'd1185); evt_chk("R4 hyst 6 hold", 1'b1);
    smp(13'd1184); evt_chk("R4 hyst 6 release", 1'b0);

    // R12 limit write acts without a sample
    wr(3'd0, 16'h0008);
    smp(13'd1000); evt_chk("R12 idle", 1'b0);
    wr(3'd1, 16'h0300); evt_chk("R12 lowered high", 1'b1);
    wr(3'd1, 16'h0500); evt_chk("R12 restored high", 1'b0);

    // R9 polarity and enable
    pol_b = 1'b1;
    wr(3'd0, 16'h000A); evt_chk("R9 active-high idle", 1'b0);
    smp(13'd1300);      evt_chk("R9 active-high asserted", 1'b1);
    wr(3'd0, 16'h0002); evt_chk("R9 disabled active-high", 1'b0);
    pol_b = 1'b0;
    wr(3'd0, 16'h0000); evt_chk("R9 disabled active-low", 1'b0);

    // R6 critical only
    wr(3'd0, 16'h000C); evt_chk("R6 window ignored", 1'b0);
    smp(13'd1600);      evt_chk("R6 at crit", 1'b1);
    smp(13'd1599);      evt_chk("R6 below crit", 1'b0);

    // R7 interrupt latch
    smp(13'd1000);
    wr(3'd0, 16'h0009); evt_chk("R7 idle", 1'b0);
    smp(13'd1300);      evt_chk("R7 enter window", 1'b1);
    smp(13'd1290);      evt_chk("R7 latched", 1'b1);
    wr(3'd0, 16'h0029); evt_chk("R7 cleared", 1'b0);
    rd_chk("R7 clear reads 0", 3'd0, 16'h0009);
    smp(13'd1000);      evt_chk("R7 leave window", 1'b1);
    wr(3'd0, 16'h0029); evt_chk("R7 cleared again", 1'b0);
    wr(3'd0, 16'h0008);
    smp(13'd1300);      evt_chk("R7 comparator", 1'b1);
    wr(3'd0, 16'h0028); evt_chk("R7 clear ignored in comparator", 1'b1);

    // R8 critical dominance
    wr(3'd0, 16'h0009);
    smp(13'd1700);      evt_chk("R8 at crit", 1'b1);
    wr(3'd0, 16'h0029); evt_chk("R8 clear blocked", 1'b1);
    smp(13'd1300);      evt_chk("R8 below crit", 1'b0);

    // R11 shutdown
    smp(13'd1000);      evt_chk("R11 setup", 1'b1);
    wr(3'd0, 16'h0029);
    smp(13'd1300);      evt_chk("R11 before shutdown", 1'b1);
    wr(3'd0, 16'h0109); evt_chk("R11 shutdown hold", 1'b1);
    smp(13'd1000);      evt_chk("R11 sample ignored", 1'b1);
    rd_chk("R11 temp frozen", 3'd4, 16'h4514);
    wr(3'd0, 16'h0129); evt_chk("R11 clear in shutdown", 1'b0);
    rd_chk("R11 cfg", 3'd0, 16'h0109);
    wr(3'd0, 16'h0008); evt_chk("R11 comparator resume", 1'b1);
    wr(3'd0, 16'h0108);
    smp(13'd1000);      evt_chk("R11 comparator frozen", 1'b1);
    wr(3'd0, 16'h0008);

    // R10 locks
    wr(3'd0, 16'h0048); rd_chk("R10 alarm lock set", 3'd0, 16'h0058);
    wr(3'd0, 16'h0146); rd_chk("R10 cfg bits blocked", 3'd0, 16'h0058);
    wr(3'd1, 16'h0100); rd_chk("R10 high locked", 3'd1, 16'h0500);
    wr(3'd2, 16'h0400); rd_chk("R10 low locked", 3'd2, 16'h0050);
    wr(3'd3, 16'h0680); rd_chk("R10 crit open", 3'd3, 16'h0680);
    wr(3'd0, 16'h0080); rd_chk("R10 crit lock set", 3'd0, 16'h00D8);
    wr(3'd3, 16'h0700); rd_chk("R10 crit locked", 3'd3, 16'h0680);
    wr(3'd0, 16'h0000); rd_chk("R10 locks sticky", 3'd0, 16'h00D8);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R10 reset clears locks", 3'd0, 16'h0000);

    finish_run();
  end
endmodule